// File: doc/BRIEF.md
# Coffee Vending Credit Controller

This block is the money-and-sale logic of a coffee machine that offers a small cup and a large cup. It takes one-dollar bills only and keeps the customer's credit as a count of quarters. A bill that would lift the credit past two dollars is refused. A selection is honoured only when the credit covers its price, which is four quarters for a small cup and five for a large one. A honoured selection fires a one-cycle dispense pulse. Any credit left over then goes back as a train of quarter-eject pulses, one per clock.

All inputs are sampled on the rising clock edge, and every output is registered. The controller answers each bill in the cycle after it arrives, with either an accept pulse or a reject pulse. While change is being paid out, the controller ignores selections and refuses bills. It returns to normal operation by itself once the quarter count reaches zero.

Top module: `coffee_credit_ctrl`

## Requirements
- R1: After reset, all outputs are low and the credit is zero quarters.
- R2: A bill pulse arriving while the controller is idle, with credit of at most 4 quarters and no sale accepted in the same cycle, produces a one-cycle `bill_ok` pulse in the next cycle and adds 4 quarters to the credit. Every bill pulse is answered in the next cycle by exactly one of `bill_ok` or `bill_rej`.
- R3: A bill that would raise the credit above 8 quarters produces `bill_rej` in the next cycle and leaves the credit unchanged. The credit never exceeds 8 quarters.
- R4: A small selection with credit of at least 4 quarters produces a one-cycle `vend_small` pulse in the next cycle and deducts 4 quarters.
- R5: A large selection with credit of at least 5 quarters produces a one-cycle `vend_large` pulse in the next cycle and deducts 5 quarters.
- R6: A selection whose price exceeds the credit produces no dispense pulse and leaves the credit unchanged.
- R7: When both selects are high in the same cycle, only the large selection is considered. The small one is dropped even if the large one cannot be afforded.
- R8: After a dispense pulse, the remaining credit is returned on `quarter_out` as consecutive one-cycle pulses, starting in the cycle right after the dispense pulse. The number of pulses equals the remaining credit. For example, a large cup bought with 8 quarters returns 3 pulses.
- R9: From an accepted selection until the change is fully paid out, selections are ignored and bills are rejected.
- R10: A bill that arrives in the same cycle as an accepted selection is rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bill_in | input | 1 | One-cycle pulse per inserted dollar bill |
| sel_small | input | 1 | Small-cup select, sampled each cycle |
| sel_large | input | 1 | Large-cup select, sampled each cycle |
| bill_ok | output | 1 | Bill taken, one-cycle pulse |
| bill_rej | output | 1 | Bill refused, one-cycle pulse |
| vend_small | output | 1 | Dispense small cup, one-cycle pulse |
| vend_large | output | 1 | Dispense large cup, one-cycle pulse |
| quarter_out | output | 1 | Eject one quarter, one pulse per quarter |

## Verification
The assertions assume that `bill_in` is a pulse lasting one cycle per bill. They also assume that a select held high is meant as one request for each cycle it is high, so a select still high after a sale is simply ignored until the payout ends. The stimulus drives every bill and select for exactly one cycle and changes inputs only on the falling edge. It issues a new request only after the quarter train has ended, except in the scenarios that deliberately probe the payout window and a bill arriving alongside a selection.

// File: rtl/coffee_vend_pkg.sv
package coffee_vend_pkg;

  typedef enum logic [1:0] {
    PICK_NONE  = 2'd0,
    PICK_SMALL = 2'd1,
    PICK_LARGE = 2'd2
  } pick_e;

  // True when adding one bill keeps credit within the ceiling.
  function automatic bit bill_fits(int unsigned credit, int unsigned bill_q,
                                   int unsigned ceiling_q);
    return (credit + bill_q) <= ceiling_q;
  endfunction

  // True when the credit covers the price.
  function automatic bit affordable(int unsigned credit, int unsigned price_q);
    return credit >= price_q;
  endfunction

endpackage

// File: rtl/pick_arbiter.sv
module pick_arbiter
  import coffee_vend_pkg::*;
#(
  parameter int unsigned CREDIT_W = 4,
  parameter int unsigned SMALL_Q  = 4,
  parameter int unsigned LARGE_Q  = 5
) (
  input  logic [CREDIT_W-1:0] credit,
  input  logic                busy,
  input  logic                sel_small,
  input  logic                sel_large,
  output pick_e               pick,
  output logic [CREDIT_W-1:0] price
);

  always_comb begin
    pick  = PICK_NONE;
    price = '0;
    if (!busy) begin
      if (sel_large) begin
        // Large wins outright; small is not a fallback (R7).
        if (affordable(int'(credit), LARGE_Q)) begin
          pick  = PICK_LARGE;
          price = CREDIT_W'(LARGE_Q);
        end
      end else if (sel_small) begin
        if (affordable(int'(credit), SMALL_Q)) begin
          pick  = PICK_SMALL;
          price = CREDIT_W'(SMALL_Q);
        end
      end
    end
  end

endmodule

// File: rtl/bill_gate.sv
module bill_gate
  import coffee_vend_pkg::*;
#(
  parameter int unsigned CREDIT_W = 4,
  parameter int unsigned BILL_Q   = 4,
  parameter int unsigned MAX_Q    = 8
) (
  input  logic [CREDIT_W-1:0] credit,
  input  logic                bill_in,
  input  logic                busy,
  input  logic                sale_go,
  output logic                take,
  output logic                refuse
);

  always_comb begin
    take   = bill_in && !busy && !sale_go &&
             bill_fits(int'(credit), BILL_Q, MAX_Q);
    refuse = bill_in && !take;
  end

endmodule

// File: rtl/credit_ledger.sv
module credit_ledger #(
  parameter int unsigned CREDIT_W = 4,
  parameter int unsigned BILL_Q   = 4,
  parameter int unsigned MAX_Q    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                take,
  input  logic                sale_go,
  input  logic [CREDIT_W-1:0] price,
  output logic [CREDIT_W-1:0] credit,
  output logic                busy,
  output logic                quarter_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit      <= '0;
      busy        <= 1'b0;
      quarter_out <= 1'b0;
    end else if (busy) begin
      if (credit != '0) begin
        credit      <= credit - CREDIT_W'(1);
        quarter_out <= 1'b1;
      end else begin
        busy        <= 1'b0;
        quarter_out <= 1'b0;
      end
    end else begin
      quarter_out <= 1'b0;
      if (sale_go) begin
        credit <= credit - price;
        busy   <= 1'b1;
      end else if (take) begin
        credit <= credit + CREDIT_W'(BILL_Q);
      end
    end
  end

  p_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
    credit <= CREDIT_W'(MAX_Q));

  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && credit != '0) |=> (quarter_out && credit == $past(credit) - CREDIT_W'(1)));

  p_sale_locks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sale_go && !busy) |=> busy);

endmodule

// File: rtl/coffee_credit_ctrl.sv
module coffee_credit_ctrl
  import coffee_vend_pkg::*;
#(
  parameter int unsigned BILL_Q  = 4,
  parameter int unsigned MAX_Q   = 8,
  parameter int unsigned SMALL_Q = 4,
  parameter int unsigned LARGE_Q = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bill_in,
  input  logic sel_small,
  input  logic sel_large,
  output logic bill_ok,
  output logic bill_rej,
  output logic vend_small,
  output logic vend_large,
  output logic quarter_out
);

  localparam int unsigned CREDIT_W = $clog2(MAX_Q + 1);

  logic [CREDIT_W-1:0] credit;
  logic [CREDIT_W-1:0] price;
  logic                busy;
  logic                sale_go;
  logic                take;
  logic                refuse;
  pick_e               pick;

  pick_arbiter #(.CREDIT_W(CREDIT_W), .SMALL_Q(SMALL_Q), .LARGE_Q(LARGE_Q)) u_pick (
    .credit   (credit),
    .busy     (busy),
    .sel_small(sel_small),
    .sel_large(sel_large),
    .pick     (pick),
    .price    (price)
  );

  assign sale_go = (pick != PICK_NONE);

  bill_gate #(.CREDIT_W(CREDIT_W), .BILL_Q(BILL_Q), .MAX_Q(MAX_Q)) u_gate (
    .credit (credit),
    .bill_in(bill_in),
    .busy   (busy),
    .sale_go(sale_go),
    .take   (take),
    .refuse (refuse)
  );

  credit_ledger #(.CREDIT_W(CREDIT_W), .BILL_Q(BILL_Q), .MAX_Q(MAX_Q)) u_ledger (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .sale_go    (sale_go),
    .price      (price),
    .credit     (credit),
    .busy       (busy),
    .quarter_out(quarter_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bill_ok    <= 1'b0;
      bill_rej   <= 1'b0;
      vend_small <= 1'b0;
      vend_large <= 1'b0;
    end else begin
      bill_ok    <= take;
      bill_rej   <= refuse;
      vend_small <= (pick == PICK_SMALL);
      vend_large <= (pick == PICK_LARGE);
    end
  end

  p_one_cup_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vend_small, vend_large}));

  p_bill_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bill_in |=> (bill_ok != bill_rej));

  p_quiet_payout_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !(vend_small || vend_large));

  p_no_coin_with_cup_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(quarter_out && (vend_small || vend_large)));

  p_short_small_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_small && !sel_large && credit < CREDIT_W'(SMALL_Q)) |=> !vend_small);

  p_bill_with_sale_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bill_in && sale_go) |=> bill_rej);

endmodule

// File: tb/coffee_credit_ctrl_test.sv
module coffee_credit_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bill_in = 1'b0, sel_small = 1'b0, sel_large = 1'b0;
  logic bill_ok, bill_rej, vend_small, vend_large, quarter_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coffee_credit_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bill_in(bill_in), .sel_small(sel_small),
    .sel_large(sel_large), .bill_ok(bill_ok), .bill_rej(bill_rej),
    .vend_small(vend_small), .vend_large(vend_large), .quarter_out(quarter_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs; on return the registered answer is visible.
  task automatic drive(input logic b, input logic s, input logic l);
    @(negedge clk);
    bill_in = b; sel_small = s; sel_large = l;
    @(negedge clk);
    bill_in = 1'b0; sel_small = 1'b0; sel_large = 1'b0;
  endtask

  task automatic insert_bill(input bit expect_ok, input string req);
    drive(1'b1, 1'b0, 1'b0);
    check(bill_ok == expect_ok && bill_rej == !expect_ok, req,
          {bill_ok, bill_rej}, expect_ok ? 2 : 1);
  endtask

  // Counts quarters; they must form one run starting right after the cup pulse.
  task automatic expect_change(input int n, input string req);
    int cnt = 0;
    bit shape = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (quarter_out) cnt++;
      if (quarter_out != (i < n)) shape = 1'b0;
      if (vend_small || vend_large) shape = 1'b0;
    end
    check(shape && cnt == n, req, cnt, n);
  endtask

  task automatic t_reset;
    check({bill_ok, bill_rej, vend_small, vend_large, quarter_out} == 5'b0,
          "R1 outputs low after reset",
          {bill_ok, bill_rej, vend_small, vend_large, quarter_out}, 0);
    drive(1'b0, 1'b1, 1'b0);
    check(!vend_small, "R1 zero credit buys nothing", vend_small, 0);
  endtask

  task automatic t_small_exact;
    insert_bill(1'b1, "R2 first bill accepted");
    drive(1'b0, 1'b1, 1'b0);
    check(vend_small && !vend_large, "R4 small dispensed", {vend_small, vend_large}, 2);
    expect_change(0, "R8 no change from exact small");
  endtask

  task automatic t_ceiling_large;
    insert_bill(1'b1, "R2 bill 1 accepted");
    insert_bill(1'b1, "R2 bill 2 accepted");
    insert_bill(1'b0, "R3 third bill rejected at ceiling");
    drive(1'b0, 1'b0, 1'b1);
    check(vend_large && !vend_small, "R5 large dispensed", {vend_small, vend_large}, 1);
    @(negedge clk);
    check(!vend_large, "R5 dispense lasts one cycle", vend_large, 0);
    check(quarter_out, "R8 first quarter follows cup", quarter_out, 1);
    expect_change(2, "R3 rejected bill left credit unchanged, 3 quarters total");
  endtask

  task automatic t_short;
    insert_bill(1'b1, "R2 bill accepted");
    drive(1'b0, 1'b0, 1'b1);
    check(!vend_large && !vend_small, "R6 large ignored on 4 quarters",
          {vend_small, vend_large}, 0);
    drive(1'b0, 1'b1, 1'b0);
    check(vend_small, "R6 credit unchanged after ignored select", vend_small, 1);
    expect_change(0, "R6 credit was exactly 4");
  endtask

  task automatic t_both;
    insert_bill(1'b1, "R2 bill accepted");
    drive(1'b0, 1'b1, 1'b1);
    check(!vend_small && !vend_large, "R7 small not a fallback",
          {vend_small, vend_large}, 0);
    insert_bill(1'b1, "R2 bill accepted to 8");
    drive(1'b0, 1'b1, 1'b1);
    check(vend_large && !vend_small, "R7 large has priority",
          {vend_small, vend_large}, 1);
    expect_change(3, "R7 change after large priority");
  endtask

  task automatic t_busy;
    int cnt = 0;
    insert_bill(1'b1, "R2 bill accepted");
    insert_bill(1'b1, "R2 bill accepted");
    drive(1'b0, 1'b1, 1'b0);
    check(vend_small, "R4 small from 8", vend_small, 1);
    @(negedge clk);
    if (quarter_out) cnt++;
    bill_in = 1'b1; sel_large = 1'b1;
    @(negedge clk);
    if (quarter_out) cnt++;
    bill_in = 1'b0; sel_large = 1'b0;
    check(bill_rej && !bill_ok, "R9 bill refused during payout", {bill_ok, bill_rej}, 1);
    check(!vend_large && !vend_small, "R9 select ignored during payout",
          {vend_small, vend_large}, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (quarter_out) cnt++;
    end
    check(cnt == 4, "R9 payout unaffected", cnt, 4);
  endtask

  task automatic t_same_cycle;
    insert_bill(1'b1, "R2 bill accepted");
    drive(1'b1, 1'b1, 1'b0);
    check(vend_small && bill_rej && !bill_ok, "R10 bill with sale rejected",
          {vend_small, bill_ok, bill_rej}, 5);
    expect_change(0, "R10 refused bill not credited");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_small_exact();
    t_ceiling_large();
    t_short();
    t_both();
    t_busy();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule